// File: doc/BRIEF.md
# Auto-Increment Packet Data Port

This block gives a host a narrow window onto packet RAM. The host first loads a 16-bit pointer word. Its three top bits choose the packet area (receive or transmit), turn on auto-increment, and set the direction (read or write). Its low bits hold a byte offset within the packet. Every data access that follows moves one, two or four bytes at that offset. When auto-increment is on, the offset then moves forward by the access size, so the host can stream a whole packet through one data port. A packet starts with a 16-bit status word and then a 16-bit length word, with the payload after them.

The block holds no RAM of its own. It drives a word-wide, synchronous-read RAM port. The word address is the packet number followed by the word index within the packet. The packet number comes from the receive queue head in the receive area, or from the transmit packet number in the transmit area. For reads, the block fetches the addressed word ahead of time into a holding register. It fetches again each time the offset moves into the next word.

Top module: `pkt_data_port`

## Requirements
- R1: After reset, ptr_rdata is 0 (transmit area, write direction, no auto-increment, offset 0), dat_ready is 1, and ram_en and dat_valid are 0.
- R2: Pointer bit 15 set to 1 selects rx_head_pkt as the packet number, and set to 0 selects tx_pkt. The RAM word address is {packet number, offset[OFS_W-1:2]}.
- R3: With pointer bit 14 set, each data access adds the access size to the offset. The size code dat_size is 0 for one byte, 1 for two bytes, 2 for four bytes, and 3 also moves four bytes. With bit 14 clear, the pointer does not change.
- R4: With pointer bit 13 clear, each dat_req produces one RAM write in the same cycle. Byte lane n holds the byte at offset n modulo 4. ram_be enables only the lanes of the access. dat_wdata is placed on those lanes, least significant byte first.
- R5: A pointer load with bit 13 set raises a RAM read at the new address in the next cycle, and dat_ready is high after the second clock edge that follows the load.
- R6: Byte and halfword reads return the addressed lanes, zero-extended. A four-byte read at offset 0 returns the status word in bits 15:0 and the length word in bits 31:16.
- R7: Consecutive halfword reads from offset 0 with auto-increment return the status, then the length, then the payload halfwords in order.
- R8: A read whose advance moves the offset into the next word drops dat_ready in the next cycle while that word is fetched.
- R9: The offset wraps from 2^OFS_W-1 back to 0 and stays inside the same packet.
- R10: dat_valid pulses for one cycle after the edge that took a read, with dat_rdata holding the result.
- R11: A dat_req in the same cycle as ptr_wr is dropped. It makes no RAM write and no advance.
- R12: Pointer bits between the offset field and bit 13 read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ptr_wr | input | 1 | Load the pointer word |
| ptr_wdata | input | 16 | Pointer word to load |
| ptr_rdata | output | 16 | Current pointer word, including the advanced offset |
| dat_req | input | 1 | Data access strobe |
| dat_size | input | 2 | Access size code (0 byte, 1 half, 2 word) |
| dat_wdata | input | 32 | Write data, least significant bytes used for narrow sizes |
| dat_ready | output | 1 | Port can take an access |
| dat_valid | output | 1 | Read result valid |
| dat_rdata | output | 32 | Read result |
| rx_head_pkt | input | PKT_W | Packet number at the receive queue head |
| tx_pkt | input | PKT_W | Packet number selected for transmit |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | PKT_W+OFS_W-2 | RAM word address |
| ram_be | output | 4 | RAM byte enables |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read data, one cycle after a read request |

## Verification
The assertions assume four things about the host:
- it raises dat_req only while dat_ready is high;
- every access is naturally aligned, so it never spans two RAM words;
- rx_head_pkt and tx_pkt stay still while a packet is being accessed;
- the RAM returns data one cycle after a read request.

The bench acts as that host. Before each access it waits for dat_ready. It loads only aligned offsets for each size, changes the packet numbers only before a pointer load, and models the RAM as a one-cycle registered pattern generator. Under those conditions the checker relates pointer loads, accesses, RAM strobes and the moving offset cycle by cycle.

// File: rtl/pd_pkg.sv
package pd_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WIDE = 2'd3
   } acc_size_e;

   typedef enum logic [1:0] {
      FS_EMPTY = 2'd0,
      FS_REQ   = 2'd1,
      FS_WAIT  = 2'd2,
      FS_FULL  = 2'd3
   } fetch_st_e;

   localparam int PTR_W     = 16;
   localparam int BIT_AREA  = 15;
   localparam int BIT_AINC  = 14;
   localparam int BIT_READ  = 13;
   localparam int LANES     = 4;
   localparam int WORD_W    = 8 * LANES;

   function automatic logic [2:0] size_step(input acc_size_e sz);
      case (sz)
         SZ_BYTE: return 3'd1;
         SZ_HALF: return 3'd2;
         default: return 3'd4;
      endcase
   endfunction
endpackage

// File: rtl/pd_ptr_reg.sv
module pd_ptr_reg #(
   parameter int OFS_W = 11
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ld,
   input  logic [pd_pkg::PTR_W-1:0] ld_val,
   input  logic                     adv,
   input  pd_pkg::acc_size_e        adv_size,
   output logic [pd_pkg::PTR_W-1:0] ptr_q,
   output logic                     area_rx,
   output logic                     ainc,
   output logic                     rd_mode,
   output logic [OFS_W-1:0]         ofs,
   output logic                     crosses
);
   import pd_pkg::*;

   logic [2:0]       step;
   logic [3:0]       lane_sum;
   logic [OFS_W-1:0] ofs_nxt;

   assign area_rx  = ptr_q[BIT_AREA];
   assign ainc     = ptr_q[BIT_AINC];
   assign rd_mode  = ptr_q[BIT_READ];
   assign ofs      = ptr_q[OFS_W-1:0];
   assign step     = size_step(adv_size);
   assign lane_sum = {2'b00, ofs[1:0]} + {1'b0, step};
   assign crosses  = ainc & lane_sum[2];
   assign ofs_nxt  = ofs + OFS_W'(step);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (ld) begin
         ptr_q <= ld_val;
      end else if (adv && ainc) begin
         ptr_q[OFS_W-1:0] <= ofs_nxt;
      end
   end
endmodule

// File: rtl/pd_fetch.sv
module pd_fetch #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic              ld_read,
   input  logic              refetch,
   input  logic [WORD_W-1:0] ram_rdata,
   output logic              fetch_req,
   output logic              hold_full,
   output logic [WORD_W-1:0] hold_q
);
   import pd_pkg::*;

   fetch_st_e st_q;

   assign fetch_req = (st_q == FS_REQ);
   assign hold_full = (st_q == FS_FULL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= FS_EMPTY;
         hold_q <= '0;
      end else if (ld) begin
         st_q <= ld_read ? FS_REQ : FS_EMPTY;
      end else begin
         unique case (st_q)
            FS_REQ:  st_q <= FS_WAIT;
            FS_WAIT: begin
               st_q   <= FS_FULL;
               hold_q <= ram_rdata;
            end
            FS_FULL: if (refetch) st_q <= FS_REQ;
            default: st_q <= FS_EMPTY;
         endcase
      end
   end
endmodule

// File: rtl/pd_lane.sv
module pd_lane #(
   parameter int LANES = 4
) (
   input  pd_pkg::acc_size_e     sz,
   input  logic [1:0]            lane_ofs,
   input  logic [8*LANES-1:0]    host_wdata,
   input  logic [8*LANES-1:0]    hold_word,
   output logic [LANES-1:0]      be,
   output logic [8*LANES-1:0]    lane_wdata,
   output logic [8*LANES-1:0]    host_rdata
);
   import pd_pkg::*;

   if (LANES != 4) begin : g_bad_lanes
      $error("pd_lane supports exactly four byte lanes");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign be[i] = (sz == SZ_BYTE) ? (lane_ofs == 2'(i)) :
                     (sz == SZ_HALF) ? (lane_ofs[1] == 1'(i / 2)) : 1'b1;
      assign lane_wdata[8*i +: 8] =
                     (sz == SZ_BYTE) ? host_wdata[7:0] :
                     (sz == SZ_HALF) ? host_wdata[8*(i % 2) +: 8] :
                                       host_wdata[8*i +: 8];
   end

   always_comb begin
      host_rdata = '0;
      unique case (sz)
         SZ_BYTE: host_rdata[7:0]  = hold_word[8*lane_ofs +: 8];
         SZ_HALF: host_rdata[15:0] = hold_word[16*lane_ofs[1] +: 16];
         default: host_rdata       = hold_word;
      endcase
   end
endmodule

// File: rtl/pkt_data_port.sv
module pkt_data_port #(
   parameter int PKT_W = 4,
   parameter int OFS_W = 11,
   localparam int AW   = PKT_W + OFS_W - 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ptr_wr,
   input  logic [15:0]      ptr_wdata,
   output logic [15:0]      ptr_rdata,
   input  logic             dat_req,
   input  logic [1:0]       dat_size,
   input  logic [31:0]      dat_wdata,
   output logic             dat_ready,
   output logic             dat_valid,
   output logic [31:0]      dat_rdata,
   input  logic [PKT_W-1:0] rx_head_pkt,
   input  logic [PKT_W-1:0] tx_pkt,
   output logic             ram_en,
   output logic             ram_we,
   output logic [AW-1:0]    ram_addr,
   output logic [3:0]       ram_be,
   output logic [31:0]      ram_wdata,
   input  logic [31:0]      ram_rdata
);
   import pd_pkg::*;

   if (OFS_W < 3 || OFS_W > 13) begin : g_bad_ofs
      $error("OFS_W must lie between 3 and 13");
   end
   if (PKT_W < 1 || PKT_W > 8) begin : g_bad_pkt
      $error("PKT_W must lie between 1 and 8");
   end

   acc_size_e        sz;
   logic             area_rx, ainc, rd_mode, crosses;
   logic [OFS_W-1:0] ofs;
   logic             fetch_req, hold_full;
   logic [31:0]      hold_word, rd_lanes;
   logic             rd_take, wr_take;
   logic [PKT_W-1:0] pkt_sel;

   assign sz      = acc_size_e'(dat_size);
   assign rd_take = dat_req & ~ptr_wr & rd_mode & hold_full;
   assign wr_take = dat_req & ~ptr_wr & ~rd_mode;
   assign pkt_sel = area_rx ? rx_head_pkt : tx_pkt;

   pd_ptr_reg #(.OFS_W(OFS_W)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld       (ptr_wr),
      .ld_val   (ptr_wdata),
      .adv      (rd_take | wr_take),
      .adv_size (sz),
      .ptr_q    (ptr_rdata),
      .area_rx  (area_rx),
      .ainc     (ainc),
      .rd_mode  (rd_mode),
      .ofs      (ofs),
      .crosses  (crosses)
   );

   pd_fetch #(.WORD_W(WORD_W)) u_fetch (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld        (ptr_wr),
      .ld_read   (ptr_wdata[BIT_READ]),
      .refetch   (rd_take & crosses),
      .ram_rdata (ram_rdata),
      .fetch_req (fetch_req),
      .hold_full (hold_full),
      .hold_q    (hold_word)
   );

   pd_lane #(.LANES(LANES)) u_lane (
      .sz         (sz),
      .lane_ofs   (ofs[1:0]),
      .host_wdata (dat_wdata),
      .hold_word  (hold_word),
      .be         (ram_be),
      .lane_wdata (ram_wdata),
      .host_rdata (rd_lanes)
   );

   assign ram_en    = fetch_req | wr_take;
   assign ram_we    = wr_take;
   assign ram_addr  = {pkt_sel, ofs[OFS_W-1:2]};
   assign dat_ready = ~rd_mode | hold_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dat_valid <= 1'b0;
         dat_rdata <= '0;
      end else begin
         dat_valid <= rd_take;
         if (rd_take) dat_rdata <= rd_lanes;
      end
   end
endmodule

// File: rtl/pkt_data_port_chk.sv
module pkt_data_port_chk #(
   parameter int PKT_W = 4,
   parameter int OFS_W = 11,
   localparam int AW   = PKT_W + OFS_W - 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ptr_wr,
   input logic [15:0]      ptr_wdata,
   input logic [15:0]      ptr_rdata,
   input logic             dat_req,
   input logic [1:0]       dat_size,
   input logic             dat_ready,
   input logic             dat_valid,
   input logic [PKT_W-1:0] rx_head_pkt,
   input logic [PKT_W-1:0] tx_pkt,
   input logic             ram_en,
   input logic             ram_we,
   input logic [AW-1:0]    ram_addr,
   input logic [3:0]       ram_be
);
   p_area_pick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ram_en |-> ram_addr[AW-1 -: PKT_W] == (ptr_rdata[15] ? rx_head_pkt : tx_pkt));

   p_half_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_req && dat_ready && !ptr_wr && ptr_rdata[14] && dat_size == 2'd1)
      |=> ptr_rdata[OFS_W-1:0] == OFS_W'($past(ptr_rdata[OFS_W-1:0]) + 2));

   p_hold_still_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_req && dat_ready && !ptr_wr && !ptr_rdata[14]) |=> $stable(ptr_rdata));

   p_write_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_req && !ptr_wr && !ptr_rdata[13]) |-> (ram_en && ram_we));

   p_lane_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_en && ram_we) |->
      ($countones(ram_be) == 1 || $countones(ram_be) == 2 || $countones(ram_be) == 4));

   p_prefetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_wr && ptr_wdata[13]) |=>
      (ram_en && !ram_we && ram_addr[OFS_W-3:0] == $past(ptr_wdata[OFS_W-1:2])));

   p_refetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_req && dat_ready && !ptr_wr && ptr_rdata[13] && ptr_rdata[14]
       && ptr_rdata[1:0] == 2'd2 && dat_size == 2'd1) |=> !dat_ready);

   p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      dat_valid |-> $past(dat_req && ptr_rdata[13]));

   p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_wr |-> !(ram_en && ram_we));
endmodule

bind pkt_data_port pkt_data_port_chk #(.PKT_W(PKT_W), .OFS_W(OFS_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ptr_wr      (ptr_wr),
   .ptr_wdata   (ptr_wdata),
   .ptr_rdata   (ptr_rdata),
   .dat_req     (dat_req),
   .dat_size    (dat_size),
   .dat_ready   (dat_ready),
   .dat_valid   (dat_valid),
   .rx_head_pkt (rx_head_pkt),
   .tx_pkt      (tx_pkt),
   .ram_en      (ram_en),
   .ram_we      (ram_we),
   .ram_addr    (ram_addr),
   .ram_be      (ram_be)
);

// File: tb/sim_pkt_data_port.sv
`timescale 1ns/1ps
module sim_pkt_data_port;
   localparam int PKT_W = 4;
   localparam int OFS_W = 11;
   localparam int AW    = PKT_W + OFS_W - 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ptr_wr = 1'b0;
   logic [15:0]      ptr_wdata = '0;
   logic [15:0]      ptr_rdata;
   logic             dat_req = 1'b0;
   logic [1:0]       dat_size = '0;
   logic [31:0]      dat_wdata = '0;
   logic             dat_ready, dat_valid;
   logic [31:0]      dat_rdata;
   logic [PKT_W-1:0] rx_head_pkt = '0;
   logic [PKT_W-1:0] tx_pkt = '0;
   logic             ram_en, ram_we;
   logic [AW-1:0]    ram_addr;
   logic [3:0]       ram_be;
   logic [31:0]      ram_wdata;
   logic [31:0]      ram_rdata = '0;

   int n_chk = 0;
   int n_fail = 0;
   int w_cnt = 0;
   logic [AW-1:0] w_addr = '0;
   logic [3:0]    w_be = '0;
   logic [31:0]   w_data = '0;
   logic          done = 1'b0;

   always #2 clk = ~clk;

   pkt_data_port #(.PKT_W(PKT_W), .OFS_W(OFS_W)) u0 (.*);

   function automatic logic [31:0] pat(input logic [AW-1:0] a);
      return {3'b110, a, 3'b001, a};
   endfunction

   function automatic logic [31:0] pick(input logic [31:0] w, input logic [1:0] o,
                                        input logic [1:0] sz);
      if (sz == 2'd0) return {24'd0, w[8*o +: 8]};
      if (sz == 2'd1) return {16'd0, w[16*o[1] +: 16]};
      return w;
   endfunction

   always @(posedge clk) begin
      if (ram_en && !ram_we) ram_rdata <= pat(ram_addr);
      if (ram_en && ram_we) begin
         w_cnt  <= w_cnt + 1;
         w_addr <= ram_addr;
         w_be   <= ram_be;
         w_data <= ram_wdata;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic load_ptr(input logic [15:0] v);
      @(negedge clk);
      ptr_wr = 1'b1;
      ptr_wdata = v;
      @(negedge clk);
      ptr_wr = 1'b0;
   endtask

   task automatic wait_ready();
      for (int n = 0; n < 20 && !dat_ready; n++) @(negedge clk);
   endtask

   task automatic access(input logic [1:0] sz, input logic [31:0] wd, output logic [31:0] rd);
      @(negedge clk);
      dat_req = 1'b1;
      dat_size = sz;
      dat_wdata = wd;
      @(negedge clk);
      dat_req = 1'b0;
      rd = dat_rdata;
   endtask

   // {pointer, size, rx_head_pkt, tx_pkt}
   localparam logic [25:0] VEC [0:7] = '{
      {16'hE000, 2'd2, 4'd3,  4'd5},
      {16'h6002, 2'd1, 4'd3,  4'd5},
      {16'hA005, 2'd0, 4'd9,  4'd2},
      {16'h6007, 2'd0, 4'd1,  4'd12},
      {16'hE7FC, 2'd2, 4'd15, 4'd0},
      {16'hE7FE, 2'd1, 4'd6,  4'd7},
      {16'h2100, 2'd2, 4'd4,  4'd8},
      {16'hE003, 2'd0, 4'd10, 4'd11}
   };

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      logic [AW-1:0] a0;
      int wc;
      repeat (3) @(negedge clk);
      chk("R1 ptr", {16'd0, ptr_rdata}, 32'd0);
      chk("R1 ready", {31'd0, dat_ready}, 32'd1);
      chk("R1 ram_en", {31'd0, ram_en}, 32'd0);
      chk("R1 valid", {31'd0, dat_valid}, 32'd0);
      rst_n = 1'b1;

      // table: area, lanes, stepping, wrap
      for (int i = 0; i < 8; i++) begin
         logic [15:0] p;
         logic [1:0]  sz;
         logic [PKT_W-1:0] pk;
         logic [OFS_W-1:0] o, oe;
         p  = VEC[i][25:10];
         sz = VEC[i][9:8];
         rx_head_pkt = VEC[i][7:4];
         tx_pkt = VEC[i][3:0];
         load_ptr(p);
         wait_ready();
         access(sz, 32'd0, rd);
         pk = p[15] ? VEC[i][7:4] : VEC[i][3:0];
         o  = p[OFS_W-1:0];
         chk("R2/R6 read data", rd, pick(pat({pk, o[OFS_W-1:2]}), o[1:0], sz));
         oe = p[14] ? o + OFS_W'((sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4) : o;
         chk("R3/R9 pointer after", {16'd0, ptr_rdata}, {16'd0, p[15:OFS_W], oe});
      end

      // prefetch timing and ordered walk
      rx_head_pkt = 4'd3;
      tx_pkt = 4'd5;
      load_ptr(16'hE000);
      chk("R5 read request", {30'd0, ram_en, ram_we}, 32'd2);
      chk("R5 not yet ready", {31'd0, dat_ready}, 32'd0);
      @(negedge clk);
      @(negedge clk);
      chk("R5 ready", {31'd0, dat_ready}, 32'd1);
      a0 = {4'd3, 9'd0};
      access(2'd1, 32'd0, rd);
      chk("R7 status", rd, {16'd0, pat(a0)[15:0]});
      chk("R10 valid", {31'd0, dat_valid}, 32'd1);
      @(negedge clk);
      chk("R10 pulse ends", {31'd0, dat_valid}, 32'd0);
      access(2'd1, 32'd0, rd);
      chk("R7 length", rd, {16'd0, pat(a0)[31:16]});
      chk("R8 ready drops", {31'd0, dat_ready}, 32'd0);
      wait_ready();
      access(2'd1, 32'd0, rd);
      chk("R7 payload 0", rd, {16'd0, pat(a0 + 1)[15:0]});
      access(2'd1, 32'd0, rd);
      chk("R7 payload 1", rd, {16'd0, pat(a0 + 1)[31:16]});

      // writes
      load_ptr(16'h4006);
      chk("R4 write ready", {31'd0, dat_ready}, 32'd1);
      access(2'd1, 32'h0000BEEF, rd);
      chk("R4 half addr", {19'd0, w_addr}, {19'd0, 4'd5, 9'd1});
      chk("R4 half be", {28'd0, w_be}, 32'hC);
      chk("R4 half data", {16'd0, w_data[31:16]}, 32'hBEEF);
      access(2'd0, 32'h0000005A, rd);
      chk("R4 byte8 be", {28'd0, w_be}, 32'h1);
      chk("R4 byte8 data", {24'd0, w_data[7:0]}, 32'h5A);
      access(2'd0, 32'h000000C3, rd);
      chk("R4 byte9 be", {28'd0, w_be}, 32'h2);
      chk("R4 byte9 data", {24'd0, w_data[15:8]}, 32'hC3);
      chk("R3 after writes", {16'd0, ptr_rdata}, 32'h400A);
      load_ptr(16'h8020);
      access(2'd2, 32'h11223344, rd);
      chk("R2 rx write addr", {19'd0, w_addr}, {19'd0, 4'd3, 9'd8});
      chk("R4 word data", w_data, 32'h11223344);
      chk("R3 no advance", {16'd0, ptr_rdata}, 32'h8020);

      // load and access together
      wc = w_cnt;
      @(negedge clk);
      ptr_wr = 1'b1;
      ptr_wdata = 16'h1810;
      dat_req = 1'b1;
      dat_size = 2'd0;
      @(negedge clk);
      ptr_wr = 1'b0;
      dat_req = 1'b0;
      @(negedge clk);
      chk("R11 no write", w_cnt, wc);
      chk("R12 pointer readback", {16'd0, ptr_rdata}, 32'h1810);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule